// File: doc/BRIEF.md
# Aliased Floating-Point Register File

This block stores the floating-point operands of a processor datapath: eight 64-bit double-precision registers and one 32-bit status word. Part of the storage has two names. Each even-numbered double register is also visible as two 32-bit single-precision registers, one for each half. The odd-numbered double registers are plain 64-bit storage and have no single-precision name.

Every data port has a 3-bit register number, a precision select and a 64-bit data bus. The block has two combinational read ports and one write port that is captured on the clock edge. Single-precision values travel in the low 32 bits of the bus. A separate port reads and writes the status word. An execution unit reads its operands through ports A and B and writes its result back through the write port. Because of the aliasing, a single-precision write changes exactly one 32-bit half and leaves every other stored bit as it was.

Top module: `fpr_file`

## Requirements
- R1: While rst_ni is low, all double registers, all single registers and the status word are zero.
- R2: A double read (dbl=1) of even number k returns single register k+1 in bits 63:32 and single register k in bits 31:0.
- R3: A single write (dbl=0) to an even number k loads bits 31:0 of the data bus into the low half of double k. No other stored bit changes.
- R4: A single write to an odd number k+1 loads bits 31:0 of the data bus into the high half of double k. No other stored bit changes.
- R5: A double write to an even number k updates single registers k and k+1 at the same clock edge.
- R6: A double read or write of an odd number uses 64-bit storage of its own. A write to it changes no other register, and no single-precision access reaches it.
- R7: A single read returns the value in bits 31:0 and zero in bits 63:32.
- R8: Reads are combinational. In the cycle of a write to an overlapping location, a read returns the old value. The new value is visible from the next cycle.
- R9: Read ports A and B decode their number and precision independently of each other.
- R10: A status write (st_we_i=1) is visible on st_rdata_o in the next cycle. Data writes do not affect the status word, and status writes do not affect data registers.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| ra_addr_i | input | 3 | Read port A register number |
| ra_dbl_i | input | 1 | Read port A precision: 1 double, 0 single |
| ra_data_o | output | 64 | Read port A data |
| rb_addr_i | input | 3 | Read port B register number |
| rb_dbl_i | input | 1 | Read port B precision: 1 double, 0 single |
| rb_data_o | output | 64 | Read port B data |
| we_i | input | 1 | Write enable |
| waddr_i | input | 3 | Write register number |
| wdbl_i | input | 1 | Write precision: 1 double, 0 single |
| wdata_i | input | 64 | Write data; single precision uses bits 31:0 |
| st_we_i | input | 1 | Status write enable |
| st_wdata_i | input | 32 | Status write data |
| st_rdata_o | output | 32 | Status read data |

## Verification
The bench keeps a reference model of eight 64-bit values and sweeps every number and precision on both read ports after each phase of writes. This catches several errors. A single write that stores the whole word would wipe the neighbouring half. Swapped halves would send single register k+1 to the low half. An odd double number folded onto the even pair would corrupt the aliased registers. The bench also reads a location in the same cycle it is written. A design that bypasses the write data to the read port would return the new value one cycle early. Finally, status and data writes are issued together, so a shared enable or a shared data path between the two would show up.

// File: rtl/fpr_pkg.sv
package fpr_pkg;
  // which storage a decoded access hits
  typedef enum logic [1:0] {
    SEL_LO   = 2'd0,
    SEL_HI   = 2'd1,
    SEL_PAIR = 2'd2,
    SEL_SOLO = 2'd3
  } fpr_sel_e;
endpackage

// File: rtl/fpr_decode.sv
module fpr_decode
  import fpr_pkg::*;
#(
  parameter int IDX_W = 3
) (
  input  logic [IDX_W-1:0] addr_i,
  input  logic             dbl_i,
  output logic [IDX_W-2:0] pair_o,
  output fpr_sel_e         sel_o
);
  assign pair_o = addr_i[IDX_W-1:1];

  always_comb begin
    if (dbl_i) sel_o = addr_i[0] ? SEL_SOLO : SEL_PAIR;
    else       sel_o = addr_i[0] ? SEL_HI   : SEL_LO;
  end
endmodule

// File: rtl/fpr_pair.sv
module fpr_pair
  import fpr_pkg::*;
#(
  parameter int SP_W = 32,
  localparam int DP_W = 2 * SP_W
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            we_i,
  input  fpr_sel_e        sel_i,
  input  logic [DP_W-1:0] wdata_i,
  output logic [SP_W-1:0] lo_o,
  output logic [SP_W-1:0] hi_o,
  output logic [DP_W-1:0] solo_o
);
  logic [SP_W-1:0] lo_q, hi_q;
  logic [DP_W-1:0] solo_q;
  logic            lo_en, hi_en, solo_en;

  assign lo_en   = we_i && (sel_i == SEL_LO || sel_i == SEL_PAIR);
  assign hi_en   = we_i && (sel_i == SEL_HI || sel_i == SEL_PAIR);
  assign solo_en = we_i && (sel_i == SEL_SOLO);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lo_q   <= '0;
      hi_q   <= '0;
      solo_q <= '0;
    end else begin
      if (lo_en)   lo_q   <= wdata_i[SP_W-1:0];
      // pair write takes upper bus half, single write takes lower
      if (hi_en)   hi_q   <= (sel_i == SEL_PAIR) ? wdata_i[DP_W-1:SP_W] : wdata_i[SP_W-1:0];
      if (solo_en) solo_q <= wdata_i;
    end
  end

  assign lo_o   = lo_q;
  assign hi_o   = hi_q;
  assign solo_o = solo_q;
endmodule

// File: rtl/fpr_rd_port.sv
module fpr_rd_port
  import fpr_pkg::*;
#(
  parameter int NUM_REGS = 8,
  parameter int SP_W     = 32,
  localparam int DP_W  = 2 * SP_W,
  localparam int IDX_W = $clog2(NUM_REGS),
  localparam int PAIRS = NUM_REGS / 2
) (
  input  logic [IDX_W-1:0]            addr_i,
  input  logic                        dbl_i,
  input  logic [PAIRS-1:0][SP_W-1:0]  lo_i,
  input  logic [PAIRS-1:0][SP_W-1:0]  hi_i,
  input  logic [PAIRS-1:0][DP_W-1:0]  solo_i,
  output logic [DP_W-1:0]             data_o
);
  logic [IDX_W-2:0] pair;
  fpr_sel_e         sel;

  fpr_decode #(.IDX_W(IDX_W)) u_dec (
    .addr_i(addr_i), .dbl_i(dbl_i), .pair_o(pair), .sel_o(sel)
  );

  always_comb begin
    unique case (sel)
      SEL_LO:   data_o = {{SP_W{1'b0}}, lo_i[pair]};
      SEL_HI:   data_o = {{SP_W{1'b0}}, hi_i[pair]};
      SEL_PAIR: data_o = {hi_i[pair], lo_i[pair]};
      default:  data_o = solo_i[pair];
    endcase
  end
endmodule

// File: rtl/fpr_file.sv
module fpr_file
  import fpr_pkg::*;
#(
  parameter int NUM_REGS = 8,
  parameter int SP_W     = 32,
  parameter int ST_W     = 32,
  localparam int DP_W  = 2 * SP_W,
  localparam int IDX_W = $clog2(NUM_REGS),
  localparam int PAIRS = NUM_REGS / 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [IDX_W-1:0] ra_addr_i,
  input  logic             ra_dbl_i,
  output logic [DP_W-1:0]  ra_data_o,
  input  logic [IDX_W-1:0] rb_addr_i,
  input  logic             rb_dbl_i,
  output logic [DP_W-1:0]  rb_data_o,
  input  logic             we_i,
  input  logic [IDX_W-1:0] waddr_i,
  input  logic             wdbl_i,
  input  logic [DP_W-1:0]  wdata_i,
  input  logic             st_we_i,
  input  logic [ST_W-1:0]  st_wdata_i,
  output logic [ST_W-1:0]  st_rdata_o
);
  logic [PAIRS-1:0][SP_W-1:0] lo_w, hi_w;
  logic [PAIRS-1:0][DP_W-1:0] solo_w;
  logic [IDX_W-2:0]           wpair;
  fpr_sel_e                   wsel;
  logic [ST_W-1:0]            st_q;

  fpr_decode #(.IDX_W(IDX_W)) u_wdec (
    .addr_i(waddr_i), .dbl_i(wdbl_i), .pair_o(wpair), .sel_o(wsel)
  );

  for (genvar p = 0; p < PAIRS; p++) begin : g_pair
    fpr_pair #(.SP_W(SP_W)) u_pair (
      .clk_i(clk_i), .rst_ni(rst_ni),
      .we_i(we_i && (wpair == p[IDX_W-2:0])),
      .sel_i(wsel), .wdata_i(wdata_i),
      .lo_o(lo_w[p]), .hi_o(hi_w[p]), .solo_o(solo_w[p])
    );
  end

  logic [1:0][IDX_W-1:0] rd_addr;
  logic [1:0]            rd_dbl;
  logic [1:0][DP_W-1:0]  rd_data;
  assign rd_addr = {rb_addr_i, ra_addr_i};
  assign rd_dbl  = {rb_dbl_i, ra_dbl_i};

  for (genvar r = 0; r < 2; r++) begin : g_rd
    fpr_rd_port #(.NUM_REGS(NUM_REGS), .SP_W(SP_W)) u_rd (
      .addr_i(rd_addr[r]), .dbl_i(rd_dbl[r]),
      .lo_i(lo_w), .hi_i(hi_w), .solo_i(solo_w),
      .data_o(rd_data[r])
    );
  end

  assign ra_data_o = rd_data[0];
  assign rb_data_o = rd_data[1];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      st_q <= '0;
    else if (st_we_i) st_q <= st_wdata_i;
  end
  assign st_rdata_o = st_q;
endmodule

// File: rtl/fpr_file_chk.sv
module fpr_file_chk #(
  parameter int NUM_REGS = 8,
  parameter int SP_W     = 32,
  parameter int ST_W     = 32,
  localparam int DP_W  = 2 * SP_W,
  localparam int IDX_W = $clog2(NUM_REGS),
  localparam int PAIRS = NUM_REGS / 2
) (
  input logic                       clk_i,
  input logic                       rst_ni,
  input logic                       ra_dbl_i,
  input logic [DP_W-1:0]            ra_data_o,
  input logic                       we_i,
  input logic [IDX_W-1:0]           waddr_i,
  input logic                       wdbl_i,
  input logic [DP_W-1:0]            wdata_i,
  input logic                       st_we_i,
  input logic [ST_W-1:0]            st_wdata_i,
  input logic [ST_W-1:0]            st_rdata_o,
  input logic [PAIRS-1:0][SP_W-1:0] lo_w,
  input logic [PAIRS-1:0][SP_W-1:0] hi_w,
  input logic [PAIRS-1:0][DP_W-1:0] solo_w
);
  logic [IDX_W-2:0] wp;
  assign wp = waddr_i[IDX_W-1:1];

  assert_sp_even_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && !wdbl_i && !waddr_i[0]) |=>
      (lo_w[$past(wp)] == $past(wdata_i[SP_W-1:0])) &&
      (hi_w == $past(hi_w)) && (solo_w == $past(solo_w)));

  assert_sp_odd_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && !wdbl_i && waddr_i[0]) |=>
      (hi_w[$past(wp)] == $past(wdata_i[SP_W-1:0])) &&
      (lo_w == $past(lo_w)) && (solo_w == $past(solo_w)));

  assert_dp_even_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && wdbl_i && !waddr_i[0]) |=>
      ({hi_w[$past(wp)], lo_w[$past(wp)]} == $past(wdata_i)) &&
      (solo_w == $past(solo_w)));

  assert_dp_odd_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && wdbl_i && waddr_i[0]) |=>
      (solo_w[$past(wp)] == $past(wdata_i)) &&
      (lo_w == $past(lo_w)) && (hi_w == $past(hi_w)));

  assert_sp_zero_ext_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ra_dbl_i |-> (ra_data_o[DP_W-1:SP_W] == '0));

  assert_status_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    st_we_i |=> (st_rdata_o == $past(st_wdata_i)));

  assert_status_hold_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !st_we_i |=> $stable(st_rdata_o));
endmodule

bind fpr_file fpr_file_chk #(.NUM_REGS(NUM_REGS), .SP_W(SP_W), .ST_W(ST_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .ra_dbl_i(ra_dbl_i), .ra_data_o(ra_data_o),
  .we_i(we_i), .waddr_i(waddr_i), .wdbl_i(wdbl_i), .wdata_i(wdata_i),
  .st_we_i(st_we_i), .st_wdata_i(st_wdata_i), .st_rdata_o(st_rdata_o),
  .lo_w(lo_w), .hi_w(hi_w), .solo_w(solo_w)
);

// File: tb/sim_fpr_file.sv
`timescale 1ns/1ps
module sim_fpr_file;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [2:0]  ra_addr_i = '0, rb_addr_i = '0, waddr_i = '0;
  logic        ra_dbl_i = 1'b0, rb_dbl_i = 1'b0, we_i = 1'b0, wdbl_i = 1'b0;
  logic [63:0] ra_data_o, rb_data_o, wdata_i = '0;
  logic        st_we_i = 1'b0;
  logic [31:0] st_wdata_i = '0, st_rdata_o;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;
  logic [63:0] ref_l [8];

  always #4 clk_i = ~clk_i;

  fpr_file u0 (.*);

  // expected read value per the requirements
  function automatic logic [63:0] expect_rd(input logic [2:0] a, input logic d);
    logic [63:0] v;
    v = ref_l[{a[2:1], 1'b0}];
    if (d) return ref_l[a];
    return a[0] ? {32'h0, v[63:32]} : {32'h0, v[31:0]};
  endfunction

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic sweep(input string req);
    for (int a = 0; a < 8; a++) begin
      for (int d = 0; d < 2; d++) begin
        ra_addr_i = 3'(a); ra_dbl_i = d[0];
        rb_addr_i = 3'(7 - a); rb_dbl_i = ~d[0];
        #1;
        check({req, " portA"}, ra_data_o, expect_rd(3'(a), d[0]));
        check({req, " R9 portB"}, rb_data_o, expect_rd(3'(7 - a), ~d[0]));
      end
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic d, input logic [63:0] v);
    @(negedge clk_i);
    we_i = 1'b1; waddr_i = a; wdbl_i = d; wdata_i = v;
    @(negedge clk_i);
    we_i = 1'b0;
    if (d) ref_l[a] = v;
    else if (a[0]) ref_l[{a[2:1], 1'b0}][63:32] = v[31:0];
    else ref_l[{a[2:1], 1'b0}][31:0] = v[31:0];
  endtask

  initial begin
    #(8 * 200000);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    if (!done) begin
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 8; i++) ref_l[i] = '0;
    // R1: reset state
    #20;
    sweep("R1 reset");
    check("R1 status reset", {32'h0, st_rdata_o}, 64'h0);
    @(negedge clk_i); rst_ni = 1'b1;

    // R5/R6/R2: double writes to all numbers, garbage upper bits ignored on single later
    for (int i = 0; i < 8; i++)
      wr(3'(i), 1'b1, {8'hD0 + 8'(i), 24'h1234_56, 8'(i) * 8'h11, 24'hABCD_EF});
    @(negedge clk_i);
    sweep("R2 R5 R6 dp");

    // R3/R4: single writes with junk in bits 63:32
    for (int i = 0; i < 8; i++) begin
      wr(3'(i), 1'b0, {32'hFFFF_FFFF, 8'h50 + 8'(i), 24'h00_7A5A});
      @(negedge clk_i);
      sweep(i % 2 == 1 ? "R4 sp odd" : "R3 sp even");
    end

    // R6: odd doubles untouched by the single writes, rewrite and recheck
    wr(3'd3, 1'b1, 64'h0123_4567_89AB_CDEF);
    wr(3'd5, 1'b1, 64'hFEDC_BA98_7654_3210);
    @(negedge clk_i);
    sweep("R6 solo");

    // R8: same-cycle read returns old value, next cycle the new one
    @(negedge clk_i);
    we_i = 1'b1; waddr_i = 3'd3; wdbl_i = 1'b0; wdata_i = 64'h0000_0000_CAFE_F00D;
    ra_addr_i = 3'd3; ra_dbl_i = 1'b0; rb_addr_i = 3'd2; rb_dbl_i = 1'b1;
    #1;
    check("R8 old portA", ra_data_o, expect_rd(3'd3, 1'b0));
    check("R8 old portB", rb_data_o, expect_rd(3'd2, 1'b1));
    ref_l[2][63:32] = 32'hCAFE_F00D;
    @(negedge clk_i);
    we_i = 1'b0;
    #1;
    check("R8 new portA", ra_data_o, 64'h0000_0000_CAFE_F00D);
    check("R8 new portB", rb_data_o, expect_rd(3'd2, 1'b1));

    // R10: status alongside data write
    @(negedge clk_i);
    st_we_i = 1'b1; st_wdata_i = 32'h5A5A_0F0F;
    we_i = 1'b1; waddr_i = 3'd6; wdbl_i = 1'b1; wdata_i = 64'h1111_2222_3333_4444;
    #1;
    check("R10 status old", {32'h0, st_rdata_o}, 64'h0);
    @(negedge clk_i);
    st_we_i = 1'b0; we_i = 1'b0; ref_l[6] = 64'h1111_2222_3333_4444;
    #1;
    check("R10 status new", {32'h0, st_rdata_o}, 64'h5A5A_0F0F);
    sweep("R10 data");
    @(negedge clk_i);
    check("R10 status hold", {32'h0, st_rdata_o}, 64'h5A5A_0F0F);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule